// File: doc/BRIEF.md
# Burst Flash Read Sequencer

This block is the device side of a word-wide flash read port that supports both plain random reads and clocked burst reads. A register array stands in for the flash cells and is filled through a preload port. After reset the block answers asynchronous reads: the word at the presented address appears combinationally while the chip is enabled.

A one-cycle configuration write selects the initial wait count, the handshaking variant (standard or reduced-wait-state) and the burst length. From then on only burst reads are served. A strobe latches a start address. The ready flag stays low for the wait count, plus a start-position penalty in the reduced variant. After that, one word is delivered per clock while an internal counter steps forward. In the reduced variant, crossing a 64-word row adds a two-cycle gap, and the ready flag is low for that gap.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the block is in asynchronous mode: while `chip_en` is high, `data_out` equals the stored word at `addr_in` and `rdy` is 1. While `chip_en` is low, `rdy` is 0 and `data_out` is 0.
- R2: A `cfg_we` pulse switches the block permanently (until reset) to synchronous mode. After that, changing `addr_in` without a strobe leaves `rdy` at 0 and `data_out` at 0.
- R3: An `addr_valid` strobe, sampled on a rising edge with `chip_en` high, latches the start address. After that edge `rdy` is 0 for `cfg_wait` cycles, plus any start penalty from R7. Then one word per cycle appears with `rdy` 1, from consecutive addresses.
- R4: In continuous mode the address wraps from the top word (4095) to 0.
- R5: With the standard variant (`cfg_reduced`=0) the stream never pauses, including when it steps from a word whose low six address bits are 3Fh into the next row.
- R6: With the reduced variant (`cfg_reduced`=1) in continuous mode, after delivering a word whose low six bits are 3Fh, `rdy` is 0 for exactly two cycles before the next word.
- R7: With the reduced variant, a start whose low six bits are 3Dh, 3Eh or 3Fh adds 1, 2 or 3 initial cycles. For a start at 3Eh or 3Fh, the first row-end gap of R6 is skipped.
- R8: `cfg_len` codes are 0 continuous, 1 eight words, 2 sixteen words, 3 thirty-two words. Fixed-length bursts wrap inside their aligned block and never take the R6 gap.
- R9: Dropping `chip_en` ends the burst at once (`rdy` 0, `data_out` 0). Raising it again delivers nothing until a new strobe.
- R10: A strobe during a burst discards it on that edge and restarts the latency count from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| addr_valid | input | 1 | Start-address strobe |
| addr_in | input | 12 | Read or start address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wait | input | 4 | Initial wait-state count |
| cfg_reduced | input | 1 | 1 selects reduced-wait-state handshaking |
| cfg_len | input | 2 | Burst length code |
| pre_we | input | 1 | Array preload write enable |
| pre_addr | input | 12 | Array preload address |
| pre_data | input | 16 | Array preload data |
| rdy | output | 1 | Valid-data flag |
| data_out | output | 16 | Read data, 0 when not valid |

## Verification
A wrong latency counter shows in the first burst cycle after the strobe: the first high `rdy` comes early or late, so the initial-wait checks catch it within about twenty cycles. A wrong address counter or row-end flag shows at the first word after 3Fh or after a block end: the data is wrong or the gap is missing or extra. Stale mode or burst state shows as soon as `chip_en` or `addr_in` changes without a strobe.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  typedef enum logic [1:0] {
    LEN_CONT = 2'd0,
    LEN_8    = 2'd1,
    LEN_16   = 2'd2,
    LEN_32   = 2'd3
  } burst_len_e;

  // Extra initial cycles in the reduced variant, from the column inside a row.
  function automatic logic [1:0] start_extra(input logic [5:0] col, input logic reduced);
    logic [1:0] r;
    r = 2'd0;
    if (reduced) begin
      unique case (col)
        6'h3D:   r = 2'd1;
        6'h3E:   r = 2'd2;
        6'h3F:   r = 2'd3;
        default: r = 2'd0;
      endcase
    end
    return r;
  endfunction

  // Starting near a row end in the reduced variant waives the first row gap.
  function automatic logic waives_gap(input logic [5:0] col, input logic reduced);
    return reduced && (col >= 6'h3E);
  endfunction

endpackage

// File: rtl/bfr_array.sv
module bfr_array #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/bfr_step.sv
module bfr_step
  import bfr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] cur,
  input  burst_len_e    len,
  input  logic          reduced,
  input  logic          waive,
  output logic [AW-1:0] nxt,
  output logic          row_end,
  output logic          gap
);
  logic [AW-1:0] mask;

  always_comb begin
    unique case (len)
      LEN_8:   mask = AW'(7);
      LEN_16:  mask = AW'(15);
      LEN_32:  mask = AW'(31);
      default: mask = '1;
    endcase
    nxt = (cur & ~mask) | ((cur + AW'(1)) & mask);
  end

  assign row_end = &cur[5:0];
  assign gap     = reduced && row_end && (len == LEN_CONT) && !waive;
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bfr_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              addr_valid,
  input  logic [AW-1:0]     addr_in,
  input  logic              cfg_we,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_reduced,
  input  logic [1:0]        cfg_len,
  input  logic              pre_we,
  input  logic [AW-1:0]     pre_addr,
  input  logic [DW-1:0]     pre_data,
  output logic              rdy,
  output logic [DW-1:0]     data_out
);
  localparam int LAT_W    = WAIT_W + 1;
  localparam int ROW_GAP  = 2;

  logic              sync_q;
  logic [WAIT_W-1:0] wait_q;
  logic              red_q;
  burst_len_e        len_q;
  logic              active_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [AW-1:0]     cur_q;
  logic              waive_q;

  logic [AW-1:0]     step_nxt;
  logic              step_row_end;
  logic              step_gap;
  logic [AW-1:0]     rd_addr;
  logic [DW-1:0]     rd_data;

  // Named events for the checker.
  logic              latch_evt;
  logic              data_valid;
  logic              boundary_gap;
  logic              wait_nz;

  assign latch_evt    = sync_q && chip_en && addr_valid && !cfg_we;
  assign data_valid   = sync_q ? (active_q && (cnt_q == '0) && chip_en) : chip_en;
  assign boundary_gap = sync_q && data_valid && step_gap;
  assign wait_nz      = (wait_q != '0);

  bfr_step #(.AW(AW)) u_step (
    .cur     (cur_q),
    .len     (len_q),
    .reduced (red_q),
    .waive   (waive_q),
    .nxt     (step_nxt),
    .row_end (step_row_end),
    .gap     (step_gap)
  );

  assign rd_addr = sync_q ? cur_q : addr_in;

  bfr_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      wait_q   <= '0;
      red_q    <= 1'b0;
      len_q    <= LEN_CONT;
      active_q <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
      waive_q  <= 1'b0;
    end else if (cfg_we) begin
      sync_q   <= 1'b1;
      wait_q   <= cfg_wait;
      red_q    <= cfg_reduced;
      len_q    <= burst_len_e'(cfg_len);
      active_q <= 1'b0;
    end else if (!chip_en) begin
      active_q <= 1'b0;
    end else if (latch_evt) begin
      active_q <= 1'b1;
      cur_q    <= addr_in;
      cnt_q    <= LAT_W'(wait_q) + LAT_W'(start_extra(addr_in[5:0], red_q));
      waive_q  <= waives_gap(addr_in[5:0], red_q);
    end else if (active_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - LAT_W'(1);
    end else if (active_q && sync_q) begin
      cur_q <= step_nxt;
      if (step_gap) cnt_q <= LAT_W'(ROW_GAP);
      if (step_row_end) waive_q <= 1'b0;
    end
  end

  assign rdy      = data_valid;
  assign data_out = data_valid ? rd_data : '0;
endmodule

// File: rtl/bfr_checks.sv
module bfr_checks #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          addr_valid,
  input logic          cfg_we,
  input logic          rdy,
  input logic          sync_mode,
  input logic          reduced,
  input logic [AW-1:0] cur_addr,
  input logic          boundary_gap,
  input logic          latch_evt,
  input logic          wait_nz
);
  logic quiet_next;
  assign quiet_next = chip_en && !addr_valid && !cfg_we;

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> !rdy);

  a_r2_sync_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> sync_mode);

  a_r3_wait_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && wait_nz) |=> !rdy);

  a_r3_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && rdy && quiet_next) |=> (cur_addr != $past(cur_addr)));

  a_r5_std_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !reduced && rdy && quiet_next) |=> (rdy || !chip_en));

  a_r6_row_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_gap && quiet_next) |=> !rdy);
endmodule

bind burst_read_seq bfr_checks #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chip_en      (chip_en),
  .addr_valid   (addr_valid),
  .cfg_we       (cfg_we),
  .rdy          (rdy),
  .sync_mode    (sync_q),
  .reduced      (red_q),
  .cur_addr     (cur_q),
  .boundary_gap (boundary_gap),
  .latch_evt    (latch_evt),
  .wait_nz      (wait_nz)
);

// File: tb/burst_read_seq_tb.sv
module burst_read_seq_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0;
  logic          addr_valid = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_wait = '0;
  logic          cfg_reduced = 1'b0;
  logic [1:0]    cfg_len = '0;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic          rdy;
  logic [DW-1:0] data_out;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  burst_read_seq u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_valid(addr_valid),
    .addr_in(addr_in), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
    .cfg_reduced(cfg_reduced), .cfg_len(cfg_len), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data), .rdy(rdy), .data_out(data_out)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37) ^ 16'h5A00);
  endfunction

  task automatic check(input string req, input logic exp_r, input logic [DW-1:0] exp_d);
    n_run++;
    if (rdy !== exp_r || data_out !== exp_d) begin
      n_fail++;
      $display("FAIL %s: rdy=%0b data=%h expected rdy=%0b data=%h", req, rdy, data_out, exp_r, exp_d);
    end
  endtask

  task automatic do_cfg(input int w, input bit red, input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wait = 4'(w); cfg_reduced = red; cfg_len = 2'(len);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Strobe a start address and compare n samples against an independent model.
  task automatic run(input string req, input int start, input int n,
                     input int w, input bit red, input int len);
    int low, a, col, blk, nx;
    bit skip, pen;
    col = start % 64;
    low = w;
    if (red && col == 61) low += 1;
    if (red && col == 62) low += 2;
    if (red && col == 63) low += 3;
    skip = red && (col >= 62);
    a = start;
    blk = (len == 1) ? 8 : (len == 2) ? 16 : (len == 3) ? 32 : NW;
    @(negedge clk);
    addr_valid = 1'b1; addr_in = AW'(start);
    @(negedge clk);
    addr_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (low > 0) begin
        check(req, 1'b0, '0);
        low--;
      end else begin
        check(req, 1'b1, pat(a));
        nx = a - (a % blk) + ((a + 1) % blk);
        pen = red && (len == 0) && (a % 64 == 63) && !skip;
        if (a % 64 == 63) skip = 1'b0;
        a = nx;
        if (pen) low = 2;
      end
    end
  endtask

  task automatic t_async_reset;  // R1
    @(negedge clk);
    chip_en = 1'b1; addr_in = 12'h005; #1;
    check("R1", 1'b1, pat(5));
    addr_in = 12'hABC; #1;
    check("R1", 1'b1, pat(12'hABC));
    chip_en = 1'b0; #1;
    check("R1", 1'b0, '0);
    chip_en = 1'b1;
  endtask

  task automatic t_sync_only;  // R2
    do_cfg(2, 1'b0, 0);
    addr_in = 12'h123; #1;
    check("R2", 1'b0, '0);
    @(negedge clk); addr_in = 12'h456; #1;
    check("R2", 1'b0, '0);
  endtask

  task automatic t_chip_drop;  // R9
    do_cfg(1, 1'b0, 0);
    run("R9", 12'h300, 4, 1, 1'b0, 0);
    @(negedge clk); chip_en = 1'b0; #1;
    check("R9", 1'b0, '0);
    @(negedge clk); #1;
    check("R9", 1'b0, '0);
    chip_en = 1'b1; #1;
    check("R9", 1'b0, '0);
    @(negedge clk); #1;
    check("R9", 1'b0, '0);
  endtask

  task automatic t_restart;  // R10
    do_cfg(2, 1'b1, 0);
    run("R10", 12'h200, 5, 2, 1'b1, 0);
    run("R10", 12'h57D, 8, 2, 1'b1, 0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = pat(i);
    end
    @(negedge clk); pre_we = 1'b0;
    #1; check("R1", 1'b0, '0);
    rst_n = 1'b1;
    t_async_reset();
    t_sync_only();
    do_cfg(3, 1'b0, 0); run("R3", 12'h010, 9, 3, 1'b0, 0);
    do_cfg(0, 1'b0, 0); run("R3", 12'h020, 4, 0, 1'b0, 0);
    do_cfg(2, 1'b0, 0); run("R5", 12'h03C, 10, 2, 1'b0, 0);
    do_cfg(0, 1'b0, 0); run("R4", 12'hFFD, 6, 0, 1'b0, 0);
    do_cfg(1, 1'b1, 0); run("R6", 12'h03A, 12, 1, 1'b1, 0);
    do_cfg(0, 1'b1, 0); run("R6", 12'hFFE, 6, 0, 1'b1, 0);
    do_cfg(2, 1'b1, 0); run("R7", 12'h03D, 10, 2, 1'b1, 0);
    run("R7", 12'h07E, 75, 2, 1'b1, 0);
    run("R7", 12'h0BF, 10, 2, 1'b1, 0);
    do_cfg(1, 1'b0, 1); run("R8", 12'h105, 12, 1, 1'b0, 1);
    do_cfg(0, 1'b0, 2); run("R8", 12'h10C, 20, 0, 1'b0, 2);
    do_cfg(1, 1'b1, 3); run("R8", 12'h03C, 12, 1, 1'b1, 3);
    t_chip_drop();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule